// File: doc/BRIEF.md
# Hashed Inverted Page Table Lookup

This block translates a (process identifier, virtual page number) pair into a physical frame number. It keeps a single translation table that all processes share, sized so that there is exactly one slot per physical frame. A slot records which virtual page of which process currently occupies that frame. The frame number is never stored. It is the index of the slot that matches.

A lookup hashes its key to pick a bucket. A small anchor array gives the first slot of that bucket's collision chain. Each slot carries a link to the next slot and a flag that marks the tail. A sequencer visits one slot per clock until one of three things happens: the key matches, the tail is reached, or a step cap runs out. The step cap keeps a damaged chain from stalling the block forever.

Software-side installation is reduced to a single-cycle write port. That port pushes a slot onto the head of its bucket's chain, and it only accepts a write while no lookup is pending.

Top module: `ipt_lookup`

## Requirements
- R1: After reset the block is idle: req_ready and ins_ready are 1, resp_valid is 0, and every bucket is empty, so any lookup misses.
- R2: The bucket of a key is the XOR of all BKT_W-bit chunks of the key {pid, vpn} (pid in the upper bits), taken from bit 0 upward, with the top chunk zero-padded.
- R3: A hit reports resp_hit=1 and, in resp_frame, the index of the slot whose stored pid and vpn both equal the request. This holds for slots 0 and FRAMES-1 too.
- R4: A slot with the same vpn but a different pid never matches.
- R5: A lookup whose bucket is empty answers a miss with resp_valid high one cycle after the accepting edge.
- R6: The chain is walked at one slot per cycle. A hit at chain position k (head = 0) answers k+2 cycles after acceptance. A miss at the tail of a chain of L slots answers L+1 cycles after acceptance.
- R7: An install puts the slot at the head of its bucket's chain, so the most recently installed slot is visited first.
- R8: ins_ready is 0 while a lookup is pending and in any idle cycle where req_valid is 1. An install offered at such a time is dropped and leaves the table unchanged.
- R9: If FRAMES slots have been visited with no match and no tail, the block answers with resp_err=1 and resp_hit=0, FRAMES+1 cycles after acceptance.
- R10: resp_valid is a one-cycle pulse. resp_hit and resp_err are never both 1. They are 0 whenever resp_valid is 0. resp_frame is 0 on any miss or error.
- R11: req_ready is 0 from the accepting edge until the response cycle. A request offered while busy is ignored and produces no response.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Lookup request strobe |
| req_ready | output | 1 | Sequencer idle; request accepted on this edge |
| req_pid | input | PID_W | Process identifier of the request |
| req_vpn | input | VPN_W | Virtual page number of the request |
| resp_valid | output | 1 | One-cycle response pulse |
| resp_hit | output | 1 | Translation found |
| resp_err | output | 1 | Step cap reached on a damaged chain |
| resp_frame | output | $clog2(FRAMES) | Matching frame index (0 unless hit) |
| ins_valid | input | 1 | Install strobe |
| ins_ready | output | 1 | Install accepted on this edge |
| ins_frame | input | $clog2(FRAMES) | Slot to write |
| ins_pid | input | PID_W | Owner process stored in the slot |
| ins_vpn | input | VPN_W | Virtual page stored in the slot |

## Verification
Each response is due a fixed number of cycles after its accepting edge. An empty bucket answers after one cycle. A hit at chain depth k answers after k+2 cycles, a tail miss on a chain of L slots after L+1, and the cap error after FRAMES+1. The bench raises a request on a falling edge and counts falling edges until it sees resp_valid, then compares that count with the value the requirements give. All outputs are sampled on falling edges, half a cycle after the registers move. Dropped installs and ignored requests are checked later, through lookups of the keys they would have planted and through the absence of any extra response pulse.

// File: rtl/ipt_pkg.sv
package ipt_pkg;
   typedef enum logic {
      WS_IDLE = 1'b0,
      WS_WALK = 1'b1
   } walk_state_e;
endpackage

// File: rtl/ipt_hash.sv
module ipt_hash #(
   parameter int KEY_W = 12,
   parameter int BKT_W = 3
) (
   input  logic [KEY_W-1:0] key,
   output logic [BKT_W-1:0] bucket
);
   localparam int NCHUNK = (KEY_W + BKT_W - 1) / BKT_W;
   localparam int PAD_W  = NCHUNK * BKT_W;

   logic [PAD_W-1:0] padded;
   assign padded = PAD_W'(key);

   generate
      if (NCHUNK == 1) begin : g_direct
         assign bucket = padded[BKT_W-1:0];
      end else begin : g_fold
         always_comb begin
            bucket = '0;
            for (int i = 0; i < NCHUNK; i++) begin
               bucket = bucket ^ padded[i*BKT_W +: BKT_W];
            end
         end
      end
   endgenerate
endmodule

// File: rtl/ipt_anchor.sv
module ipt_anchor #(
   parameter int BUCKETS = 8,
   parameter int FRAMES  = 16
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic [$clog2(BUCKETS)-1:0] lk_bkt,
   output logic                       lk_valid,
   output logic [$clog2(FRAMES)-1:0]  lk_head,
   input  logic [$clog2(BUCKETS)-1:0] in_bkt,
   output logic                       in_valid,
   output logic [$clog2(FRAMES)-1:0]  in_head,
   input  logic                       wr_en,
   input  logic [$clog2(FRAMES)-1:0]  wr_head
);
   localparam int FRAME_W = $clog2(FRAMES);

   logic               vld_arr  [BUCKETS];
   logic [FRAME_W-1:0] head_arr [BUCKETS];

   generate
      for (genvar b = 0; b < BUCKETS; b++) begin : g_bkt
         logic               vld_q;
         logic [FRAME_W-1:0] head_q;
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               vld_q  <= 1'b0;
               head_q <= '0;
            end else if (wr_en && in_bkt == b) begin
               vld_q  <= 1'b1;
               head_q <= wr_head;
            end
         end
         assign vld_arr[b]  = vld_q;
         assign head_arr[b] = head_q;
      end
   endgenerate

   assign lk_valid = vld_arr[lk_bkt];
   assign lk_head  = head_arr[lk_bkt];
   assign in_valid = vld_arr[in_bkt];
   assign in_head  = head_arr[in_bkt];
endmodule

// File: rtl/ipt_slots.sv
module ipt_slots #(
   parameter int FRAMES = 16,
   parameter int PID_W  = 4,
   parameter int VPN_W  = 8
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      wr_en,
   input  logic [$clog2(FRAMES)-1:0] wr_idx,
   input  logic [PID_W-1:0]          wr_pid,
   input  logic [VPN_W-1:0]          wr_vpn,
   input  logic [$clog2(FRAMES)-1:0] wr_next,
   input  logic                      wr_tail,
   input  logic [$clog2(FRAMES)-1:0] rd_idx,
   output logic [PID_W-1:0]          rd_pid,
   output logic [VPN_W-1:0]          rd_vpn,
   output logic [$clog2(FRAMES)-1:0] rd_next,
   output logic                      rd_tail
);
   localparam int FRAME_W = $clog2(FRAMES);

   logic [PID_W-1:0]   pid_arr  [FRAMES];
   logic [VPN_W-1:0]   vpn_arr  [FRAMES];
   logic [FRAME_W-1:0] next_arr [FRAMES];
   logic               tail_arr [FRAMES];

   generate
      for (genvar f = 0; f < FRAMES; f++) begin : g_slot
         logic [PID_W-1:0]   pid_q;
         logic [VPN_W-1:0]   vpn_q;
         logic [FRAME_W-1:0] next_q;
         logic               tail_q;
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               pid_q  <= '0;
               vpn_q  <= '0;
               next_q <= '0;
               tail_q <= 1'b1;
            end else if (wr_en && wr_idx == f) begin
               pid_q  <= wr_pid;
               vpn_q  <= wr_vpn;
               next_q <= wr_next;
               tail_q <= wr_tail;
            end
         end
         assign pid_arr[f]  = pid_q;
         assign vpn_arr[f]  = vpn_q;
         assign next_arr[f] = next_q;
         assign tail_arr[f] = tail_q;
      end
   endgenerate

   assign rd_pid  = pid_arr[rd_idx];
   assign rd_vpn  = vpn_arr[rd_idx];
   assign rd_next = next_arr[rd_idx];
   assign rd_tail = tail_arr[rd_idx];
endmodule

// File: rtl/ipt_walker.sv
module ipt_walker
   import ipt_pkg::*;
#(
   parameter int FRAMES = 16,
   parameter int PID_W  = 4,
   parameter int VPN_W  = 8
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      req_valid,
   input  logic [PID_W-1:0]          req_pid,
   input  logic [VPN_W-1:0]          req_vpn,
   output logic                      idle,
   input  logic                      anc_valid,
   input  logic [$clog2(FRAMES)-1:0] anc_head,
   output logic [$clog2(FRAMES)-1:0] cur_idx,
   input  logic [PID_W-1:0]          slot_pid,
   input  logic [VPN_W-1:0]          slot_vpn,
   input  logic [$clog2(FRAMES)-1:0] slot_next,
   input  logic                      slot_tail,
   output logic                      resp_valid,
   output logic                      resp_hit,
   output logic                      resp_err,
   output logic [$clog2(FRAMES)-1:0] resp_frame
);
   localparam int FRAME_W = $clog2(FRAMES);
   localparam logic [FRAME_W-1:0] STEP_CAP = FRAME_W'(FRAMES - 1);

   walk_state_e        state_q;
   logic [PID_W-1:0]   key_pid_q;
   logic [VPN_W-1:0]   key_vpn_q;
   logic [FRAME_W-1:0] cur_q;
   logic [FRAME_W-1:0] steps_q;
   logic               match;

   assign idle    = (state_q == WS_IDLE);
   assign cur_idx = cur_q;
   assign match   = (slot_pid == key_pid_q) && (slot_vpn == key_vpn_q);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q    <= WS_IDLE;
         key_pid_q  <= '0;
         key_vpn_q  <= '0;
         cur_q      <= '0;
         steps_q    <= '0;
         resp_valid <= 1'b0;
         resp_hit   <= 1'b0;
         resp_err   <= 1'b0;
         resp_frame <= '0;
      end else begin
         resp_valid <= 1'b0;
         resp_hit   <= 1'b0;
         resp_err   <= 1'b0;
         resp_frame <= '0;
         case (state_q)
            WS_IDLE: begin
               if (req_valid) begin
                  key_pid_q <= req_pid;
                  key_vpn_q <= req_vpn;
                  if (anc_valid) begin
                     cur_q   <= anc_head;
                     steps_q <= '0;
                     state_q <= WS_WALK;
                  end else begin
                     resp_valid <= 1'b1;
                  end
               end
            end
            WS_WALK: begin
               if (match) begin
                  resp_valid <= 1'b1;
                  resp_hit   <= 1'b1;
                  resp_frame <= cur_q;
                  state_q    <= WS_IDLE;
               end else if (slot_tail) begin
                  resp_valid <= 1'b1;
                  state_q    <= WS_IDLE;
               end else if (steps_q == STEP_CAP) begin
                  resp_valid <= 1'b1;
                  resp_err   <= 1'b1;
                  state_q    <= WS_IDLE;
               end else begin
                  cur_q   <= slot_next;
                  steps_q <= steps_q + 1'b1;
               end
            end
            default: state_q <= WS_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/ipt_lookup.sv
module ipt_lookup #(
   parameter int FRAMES  = 16,
   parameter int BUCKETS = 8,
   parameter int PID_W   = 4,
   parameter int VPN_W   = 8
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      req_valid,
   output logic                      req_ready,
   input  logic [PID_W-1:0]          req_pid,
   input  logic [VPN_W-1:0]          req_vpn,
   output logic                      resp_valid,
   output logic                      resp_hit,
   output logic                      resp_err,
   output logic [$clog2(FRAMES)-1:0] resp_frame,
   input  logic                      ins_valid,
   output logic                      ins_ready,
   input  logic [$clog2(FRAMES)-1:0] ins_frame,
   input  logic [PID_W-1:0]          ins_pid,
   input  logic [VPN_W-1:0]          ins_vpn
);
   localparam int FRAME_W = $clog2(FRAMES);
   localparam int BKT_W   = $clog2(BUCKETS);
   localparam int KEY_W   = PID_W + VPN_W;

   generate
      if (FRAMES < 2 || (1 << FRAME_W) != FRAMES) begin : g_bad_frames
         $error("FRAMES must be a power of two, at least 2");
      end
      if (BUCKETS < 2 || (1 << BKT_W) != BUCKETS) begin : g_bad_buckets
         $error("BUCKETS must be a power of two, at least 2");
      end
      if (PID_W < 1 || VPN_W < 1) begin : g_bad_key
         $error("key fields must be at least one bit wide");
      end
   endgenerate

   logic [BKT_W-1:0]   req_bkt, ins_bkt;
   logic               lk_valid, in_valid;
   logic [FRAME_W-1:0] lk_head, in_head;
   logic [FRAME_W-1:0] cur_idx;
   logic [PID_W-1:0]   slot_pid;
   logic [VPN_W-1:0]   slot_vpn;
   logic [FRAME_W-1:0] slot_next;
   logic               slot_tail;
   logic               idle;
   logic               ins_fire;

   assign req_ready = idle;
   assign ins_ready = idle && !req_valid;
   assign ins_fire  = ins_valid && ins_ready;

   ipt_hash #(.KEY_W(KEY_W), .BKT_W(BKT_W)) u_req_hash (
      .key    ({req_pid, req_vpn}),
      .bucket (req_bkt)
   );

   ipt_hash #(.KEY_W(KEY_W), .BKT_W(BKT_W)) u_ins_hash (
      .key    ({ins_pid, ins_vpn}),
      .bucket (ins_bkt)
   );

   ipt_anchor #(.BUCKETS(BUCKETS), .FRAMES(FRAMES)) u_anchor (
      .clk      (clk),
      .rst_n    (rst_n),
      .lk_bkt   (req_bkt),
      .lk_valid (lk_valid),
      .lk_head  (lk_head),
      .in_bkt   (ins_bkt),
      .in_valid (in_valid),
      .in_head  (in_head),
      .wr_en    (ins_fire),
      .wr_head  (ins_frame)
   );

   ipt_slots #(.FRAMES(FRAMES), .PID_W(PID_W), .VPN_W(VPN_W)) u_slots (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (ins_fire),
      .wr_idx  (ins_frame),
      .wr_pid  (ins_pid),
      .wr_vpn  (ins_vpn),
      .wr_next (in_head),
      .wr_tail (!in_valid),
      .rd_idx  (cur_idx),
      .rd_pid  (slot_pid),
      .rd_vpn  (slot_vpn),
      .rd_next (slot_next),
      .rd_tail (slot_tail)
   );

   ipt_walker #(.FRAMES(FRAMES), .PID_W(PID_W), .VPN_W(VPN_W)) u_walker (
      .clk        (clk),
      .rst_n      (rst_n),
      .req_valid  (req_valid),
      .req_pid    (req_pid),
      .req_vpn    (req_vpn),
      .idle       (idle),
      .anc_valid  (lk_valid),
      .anc_head   (lk_head),
      .cur_idx    (cur_idx),
      .slot_pid   (slot_pid),
      .slot_vpn   (slot_vpn),
      .slot_next  (slot_next),
      .slot_tail  (slot_tail),
      .resp_valid (resp_valid),
      .resp_hit   (resp_hit),
      .resp_err   (resp_err),
      .resp_frame (resp_frame)
   );
endmodule

// File: rtl/ipt_lookup_chk.sv
module ipt_lookup_chk #(
   parameter int FRAME_W = 4
) (
   input logic               clk,
   input logic               rst_n,
   input logic               req_valid,
   input logic               req_ready,
   input logic               ins_ready,
   input logic               resp_valid,
   input logic               resp_hit,
   input logic               resp_err,
   input logic [FRAME_W-1:0] resp_frame
);
   // R10
   hit_err_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      resp_valid |-> !(resp_hit && resp_err));

   // R10
   flags_need_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !resp_valid |-> (!resp_hit && !resp_err));

   // R10
   miss_frame_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (resp_valid && !resp_hit) |-> (resp_frame == '0));

   // R8
   ins_blocked_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !req_ready |-> !ins_ready);

   // R8
   ins_yields_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |-> !ins_ready);

   // R11
   accept_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_ready) |=> (!req_ready || resp_valid));

   // R11
   resp_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      resp_valid |-> req_ready);
endmodule

bind ipt_lookup ipt_lookup_chk #(.FRAME_W($clog2(FRAMES))) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .req_valid  (req_valid),
   .req_ready  (req_ready),
   .ins_ready  (ins_ready),
   .resp_valid (resp_valid),
   .resp_hit   (resp_hit),
   .resp_err   (resp_err),
   .resp_frame (resp_frame)
);

// File: tb/ipt_lookup_test.sv
module ipt_lookup_test;
   localparam int CLK_PERIOD = 10;
   localparam int FRAMES  = 16;
   localparam int BUCKETS = 8;
   localparam int PID_W   = 4;
   localparam int VPN_W   = 8;
   localparam int FW      = 4;
   localparam int VEC_W   = PID_W + VPN_W + 1 + FW + 6;

   // {pid, vpn, exp_hit, exp_frame, exp_latency}
   // buckets (R2): (1,10)(1,19)(1,02)(8,10) -> 6; (3,45)(3,4C) -> 1; (2,10) -> 3
   localparam logic [VEC_W-1:0] VECS [8] = '{
      {4'h1, 8'h02, 1'b1, 4'd12, 6'd2},
      {4'h1, 8'h19, 1'b1, 4'd9,  6'd3},
      {4'h1, 8'h10, 1'b1, 4'd5,  6'd4},
      {4'h8, 8'h10, 1'b0, 4'd0,  6'd4},
      {4'h2, 8'h10, 1'b0, 4'd0,  6'd1},
      {4'h3, 8'h4C, 1'b1, 4'd15, 6'd2},
      {4'h3, 8'h45, 1'b1, 4'd0,  6'd3},
      {4'h1, 8'h11, 1'b0, 4'd0,  6'd1}
   };

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic            req_valid = 1'b0;
   logic            req_ready;
   logic [PID_W-1:0] req_pid = '0;
   logic [VPN_W-1:0] req_vpn = '0;
   logic            resp_valid, resp_hit, resp_err;
   logic [FW-1:0]   resp_frame;
   logic            ins_valid = 1'b0;
   logic            ins_ready;
   logic [FW-1:0]   ins_frame = '0;
   logic [PID_W-1:0] ins_pid = '0;
   logic [VPN_W-1:0] ins_vpn = '0;

   int checks = 0;
   int fails  = 0;
   int cycles = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   ipt_lookup #(.FRAMES(FRAMES), .BUCKETS(BUCKETS), .PID_W(PID_W), .VPN_W(VPN_W)) uut (
      .clk(clk), .rst_n(rst_n),
      .req_valid(req_valid), .req_ready(req_ready), .req_pid(req_pid), .req_vpn(req_vpn),
      .resp_valid(resp_valid), .resp_hit(resp_hit), .resp_err(resp_err), .resp_frame(resp_frame),
      .ins_valid(ins_valid), .ins_ready(ins_ready), .ins_frame(ins_frame),
      .ins_pid(ins_pid), .ins_vpn(ins_vpn)
   );

   always @(posedge clk) begin
      cycles <= cycles + 1;
      if (cycles > 20000) begin
         fails = fails + 1;
         $display("FAIL watchdog: actual %0d cycles, expected completion", cycles);
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end

   task automatic check(input string tag, input int act, input int exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
      end
   endtask

   task automatic install(input int frame, input int pid, input int vpn);
      @(negedge clk);
      ins_valid = 1'b1;
      ins_frame = FW'(frame);
      ins_pid   = PID_W'(pid);
      ins_vpn   = VPN_W'(vpn);
      #1 check("R7 ins_ready when idle", int'(ins_ready), 1);
      @(negedge clk);
      ins_valid = 1'b0;
   endtask

   // waits for the response of a request raised at the last negedge
   task automatic wait_resp(output int lat);
      lat = 1;
      @(negedge clk);
      req_valid = 1'b0;
      while (!resp_valid && lat < 64) begin
         @(negedge clk);
         lat++;
      end
   endtask

   task automatic lookup(input string tag, input int pid, input int vpn,
                         input int ehit, input int eerr, input int eframe, input int elat);
      int lat;
      @(negedge clk);
      req_valid = 1'b1;
      req_pid   = PID_W'(pid);
      req_vpn   = VPN_W'(vpn);
      wait_resp(lat);
      check({tag, " hit"},   int'(resp_hit), ehit);
      check({tag, " err"},   int'(resp_err), eerr);
      check({tag, " frame"}, int'(resp_frame), eframe);
      check({tag, " latency"}, lat, elat);
   endtask

   initial begin
      int lat;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      check("R1 req_ready", int'(req_ready), 1);
      check("R1 ins_ready", int'(ins_ready), 1);
      check("R1 resp_valid", int'(resp_valid), 0);
      lookup("R1 R5 empty after reset", 1, 8'h10, 0, 0, 0, 1);

      // R7: chain in bucket 6 is 12 -> 9 -> 5; bucket 1 is 15 -> 0
      install(5, 1, 8'h10);
      install(9, 1, 8'h19);
      install(12, 1, 8'h02);
      install(0, 3, 8'h45);
      install(15, 3, 8'h4C);

      // R2 R3 R4 R6 R7 vector walk
      for (int i = 0; i < 8; i++) begin
         logic [VEC_W-1:0] v;
         v = VECS[i];
         lookup($sformatf("R3 R4 R6 vec%0d", i), int'(v[VEC_W-1 -: PID_W]),
                int'(v[VEC_W-PID_W-1 -: VPN_W]), int'(v[FW+6]), 0,
                int'(v[FW+5 -: FW]), int'(v[5:0]));
      end

      // R8 R11: offer an install and a second request while a 4-cycle miss walks
      @(negedge clk);
      req_valid = 1'b1; req_pid = 4'h8; req_vpn = 8'h10;
      @(negedge clk);
      req_pid = 4'h1; req_vpn = 8'h02;
      ins_valid = 1'b1; ins_frame = 4'd7; ins_pid = 4'h2; ins_vpn = 8'h10;
      #1;
      check("R11 req_ready busy", int'(req_ready), 0);
      check("R8 ins_ready busy", int'(ins_ready), 0);
      lat = 1;
      while (!resp_valid && lat < 64) begin
         @(negedge clk);
         lat++;
      end
      req_valid = 1'b0;
      ins_valid = 1'b0;
      check("R11 first request answered", int'(resp_hit), 0);
      check("R11 first request latency", lat, 4);
      for (int k = 0; k < 3; k++) begin
         @(negedge clk);
         check("R11 no response for ignored request", int'(resp_valid), 0);
      end
      lookup("R8 busy install dropped", 2, 8'h10, 0, 0, 0, 1);

      // R8: request and install in the same idle cycle, request wins
      @(negedge clk);
      req_valid = 1'b1; req_pid = 4'h1; req_vpn = 8'h02;
      ins_valid = 1'b1; ins_frame = 4'd6; ins_pid = 4'h7; ins_vpn = 8'h00;
      #1 check("R8 ins_ready with req_valid", int'(ins_ready), 0);
      wait_resp(lat);
      ins_valid = 1'b0;
      check("R8 concurrent request hit", int'(resp_hit), 1);
      check("R8 concurrent request frame", int'(resp_frame), 12);
      lookup("R8 concurrent install dropped", 7, 8'h00, 0, 0, 0, 1);

      // R9: installing frame 3 twice into bucket 3 makes a self loop
      install(3, 2, 8'h10);
      install(3, 2, 8'h10);
      lookup("R3 R9 loop head hit", 2, 8'h10, 1, 0, 3, 2);
      lookup("R9 step cap", 2, 8'h19, 0, 1, 0, FRAMES + 1);
      @(negedge clk);
      check("R10 pulse ends", int'(resp_valid), 0);
      check("R9 idle after error", int'(req_ready), 1);

      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end
endmodule